// File: doc/BRIEF.md
# Dual-Group I/O Channel Sequencer

The sequencer runs two transaction groups of an I/O channel side by side. The poll group serves cycle-steal requests from the channel's devices and the processor's interrupt-poll request. The service group serves direct program control (DPC) requests from the processor, together with the work that the poll group hands on to it. Each group holds at most one transaction. A group arbitrates only on a cycle in which it is free. A won transaction is announced by a one-cycle grant, and the group stays busy until its done input is seen.

The two arbiters are chained. Every poll-group grant becomes a hand-off request into the service group, where it competes with DPC. The poll group will not start another transaction until the service group has taken its hand-off. Requests are latched on arrival, so a request that shows up while a group is busy waits for that group's next free cycle. In initial-program-load (IPL) mode only one selected device may win the poll group. All other requesters are held back until the mode ends.

Top module: `io_chan_seq`

## Requirements
- R1: While rst_ni is low, and after it is released with no request present, poll_busy_o, svc_busy_o, poll_gnt_o and svc_gnt_o are all 0.
- R2: When the poll group is free and a request is present before a clock edge, poll_gnt_o is 1 for exactly the one cycle after that edge. In that cycle poll_src_o shows the winner (0 = cycle steal, 1 = interrupt poll) and poll_dev_o shows the device index (0 when the winner is the interrupt poll). poll_busy_o is 1 from that cycle on.
- R3: When several poll requests are present on a free cycle, a cycle-steal request wins over the interrupt-poll request, and the lowest device index wins among cycle-steal requests. The requests that lose stay pending.
- R4: While a group is busy it grants nothing. A done input seen at an edge clears that group's busy flag after the edge, and the group arbitrates again at the next edge. A request held for only one cycle during a busy period is served later.
- R5: A poll grant is a hand-off request to the service group in the same cycle. If the service group is free, svc_gnt_o follows on the next cycle with svc_src_o = 0 (hand-off).
- R6: When a hand-off and a DPC request are both pending on a free service cycle, the hand-off wins. DPC grants show svc_src_o = 1.
- R7: The two groups may be busy at the same time. While a hand-off waits for the service group, the poll group starts no new transaction, even after its own done.
- R8: Each group has at most one transaction active, and at most one requester wins each grant.
- R9: req_err_o is 1 combinationally whenever ipoll_req_i and dpc_req_i are both 1, and 0 otherwise.
- R10: While ipl_mode_i is 1, only the cycle-steal request of device ipl_dev_i can win the poll group, and DPC cannot win the service group. Masked requests stay pending and are served after the mode ends.
- R11: Driving rst_ni low clears both busy flags and all pending requests at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ipl_mode_i | input | 1 | IPL mode: only the selected device may use the channel |
| ipl_dev_i | input | DEV_W | Device selected for IPL |
| ipoll_req_i | input | 1 | Processor interrupt-poll request |
| cs_req_i | input | N_DEV | Cycle-steal requests, one per device |
| dpc_req_i | input | 1 | Processor DPC request |
| poll_done_i | input | 1 | Ends the active poll-group transaction |
| svc_done_i | input | 1 | Ends the active service-group transaction |
| poll_gnt_o | output | 1 | One-cycle poll-group grant pulse |
| poll_src_o | output | 1 | Poll winner: 0 cycle steal, 1 interrupt poll |
| poll_dev_o | output | DEV_W | Device index of a cycle-steal grant |
| poll_busy_o | output | 1 | Poll group has an active transaction |
| svc_gnt_o | output | 1 | One-cycle service-group grant pulse |
| svc_src_o | output | 1 | Service winner: 0 hand-off, 1 DPC |
| svc_busy_o | output | 1 | Service group has an active transaction |
| req_err_o | output | 1 | Interrupt poll and DPC asserted together |

## Verification
A stuck busy flag shows as a missing grant on the cycle after done. A lost pending bit shows as a request that is never granted once the competing traffic drains. The hand-off chain is checked to the exact cycle. A hand-off that is dropped or granted twice shows up either as no service grant on the cycle after the poll grant, or as a second hand-off grant with no poll grant before it. The priority and IPL checks look at the winner's source and device index on the first grant after a free cycle. A wrong order therefore shows up at once rather than after later traffic.

// File: rtl/io_chan_pkg.sv
package io_chan_pkg;
  typedef enum logic {
    POLL_CSTEAL = 1'b0,
    POLL_IPOLL  = 1'b1
  } poll_src_e;

  typedef enum logic {
    SVC_HANDOFF = 1'b0,
    SVC_DPC     = 1'b1
  } svc_src_e;

  localparam int unsigned SVC_N_REQ = 2;
endpackage

// File: rtl/req_hold.sv
// Sticky request latch: set by input level, cleared by its grant.
module req_hold #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= (q_q | set_i) & ~clr_i;
  end

  // a request visible in the same cycle it arrives
  assign pend_o = q_q | set_i;

  // R4
  pend_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_q != '0 && clr_i == '0) |=> ((q_q & $past(q_q)) == $past(q_q)));
endmodule

// File: rtl/grp_core.sv
// One transaction group: fixed-priority pick on free cycles, busy until done.
module grp_core #(
  parameter  int N_REQ = 2,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  input  logic             hold_i,
  input  logic             done_i,
  output logic             gnt_o,
  output logic [IDX_W-1:0] gnt_idx_o,
  output logic [N_REQ-1:0] gnt_vec_o,
  output logic             busy_o
);
  logic             busy_q, gnt_q;
  logic [IDX_W-1:0] idx_q, sel;
  logic             any_req;

  assign any_req = |req_i;

  // lowest index wins
  always_comb begin
    sel = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (req_i[i]) sel = IDX_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      gnt_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      gnt_q <= 1'b0;
      if (busy_q) begin
        if (done_i) busy_q <= 1'b0;
      end else if (!hold_i && any_req) begin
        busy_q <= 1'b1;
        gnt_q  <= 1'b1;
        idx_q  <= sel;
      end
    end
  end

  always_comb begin
    gnt_vec_o = '0;
    if (gnt_q) gnt_vec_o[idx_q] = 1'b1;
  end

  assign gnt_o     = gnt_q;
  assign gnt_idx_o = idx_q;
  assign busy_o    = busy_q;

  // R2
  gnt_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_q |-> busy_q);
  // R4
  busy_no_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_i) |=> (busy_q && !gnt_q));
  // R4
  done_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && done_i) |=> !busy_q);
  // R8
  one_winner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_vec_o));
  // R2
  gnt_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_q |=> !gnt_q);
endmodule

// File: rtl/io_chan_seq.sv
module io_chan_seq
  import io_chan_pkg::*;
#(
  parameter  int N_DEV = 8,
  localparam int DEV_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ipl_mode_i,
  input  logic [DEV_W-1:0] ipl_dev_i,
  input  logic             ipoll_req_i,
  input  logic [N_DEV-1:0] cs_req_i,
  input  logic             dpc_req_i,
  input  logic             poll_done_i,
  input  logic             svc_done_i,
  output logic             poll_gnt_o,
  output logic             poll_src_o,
  output logic [DEV_W-1:0] poll_dev_o,
  output logic             poll_busy_o,
  output logic             svc_gnt_o,
  output logic             svc_src_o,
  output logic             svc_busy_o,
  output logic             req_err_o
);
  localparam int P_N   = N_DEV + 1;
  localparam int P_W   = $clog2(P_N);
  localparam int S_W   = (SVC_N_REQ > 1) ? $clog2(SVC_N_REQ) : 1;
  localparam logic [P_W-1:0] IPOLL_IDX = P_W'(N_DEV);

  logic [N_DEV-1:0]     cs_pend, cs_mask;
  logic                 ipoll_pend, dpc_pend, ho_pend;
  logic [P_N-1:0]       poll_req, poll_gvec;
  logic [P_W-1:0]       poll_idx;
  logic [SVC_N_REQ-1:0] svc_req, svc_gvec;
  logic [S_W-1:0]       svc_idx;
  logic                 poll_gnt;

  req_hold #(.W(N_DEV)) u_cs_hold (
    .clk_i, .rst_ni, .set_i(cs_req_i), .clr_i(poll_gvec[N_DEV-1:0]), .pend_o(cs_pend)
  );
  req_hold #(.W(1)) u_ipoll_hold (
    .clk_i, .rst_ni, .set_i(ipoll_req_i), .clr_i(poll_gvec[N_DEV]), .pend_o(ipoll_pend)
  );
  req_hold #(.W(1)) u_dpc_hold (
    .clk_i, .rst_ni, .set_i(dpc_req_i), .clr_i(svc_gvec[SVC_DPC]), .pend_o(dpc_pend)
  );
  // poll grant becomes a service-group requester
  req_hold #(.W(1)) u_ho_hold (
    .clk_i, .rst_ni, .set_i(poll_gnt), .clr_i(svc_gvec[SVC_HANDOFF]), .pend_o(ho_pend)
  );

  assign cs_mask  = ipl_mode_i ? (N_DEV'(1) << ipl_dev_i) : '1;
  assign poll_req = {ipoll_pend & ~ipl_mode_i, cs_pend & cs_mask};

  grp_core #(.N_REQ(P_N)) u_poll (
    .clk_i, .rst_ni,
    .req_i     (poll_req),
    .hold_i    (ho_pend),
    .done_i    (poll_done_i),
    .gnt_o     (poll_gnt),
    .gnt_idx_o (poll_idx),
    .gnt_vec_o (poll_gvec),
    .busy_o    (poll_busy_o)
  );

  assign svc_req[SVC_HANDOFF] = ho_pend;
  assign svc_req[SVC_DPC]     = dpc_pend & ~ipl_mode_i;

  grp_core #(.N_REQ(SVC_N_REQ)) u_svc (
    .clk_i, .rst_ni,
    .req_i     (svc_req),
    .hold_i    (1'b0),
    .done_i    (svc_done_i),
    .gnt_o     (svc_gnt_o),
    .gnt_idx_o (svc_idx),
    .gnt_vec_o (svc_gvec),
    .busy_o    (svc_busy_o)
  );

  assign poll_gnt_o = poll_gnt;
  assign poll_src_o = (poll_idx == IPOLL_IDX);
  assign poll_dev_o = poll_src_o ? '0 : poll_idx[DEV_W-1:0];
  assign svc_src_o  = svc_idx[0];
  assign req_err_o  = ipoll_req_i & dpc_req_i;

  // R5
  handoff_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_gnt_o && !svc_busy_o) |=> (svc_gnt_o && svc_src_o == SVC_HANDOFF));
  // R7
  poll_wait_ho_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ho_pend && !poll_busy_o) |=> !poll_gnt_o);
  // R10
  ipl_poll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_gnt_o && $past(ipl_mode_i)) |->
      (poll_src_o == POLL_CSTEAL && poll_dev_o == $past(ipl_dev_i)));
  // R10
  ipl_svc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_gnt_o && $past(ipl_mode_i)) |-> (svc_src_o == SVC_HANDOFF));
endmodule

// File: tb/io_chan_seq_bench.sv
module io_chan_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_DEV = 8;
  localparam int DEV_W = 3;

  logic             clk = 0, rst_ni = 0;
  logic             ipl_mode = 0;
  logic [DEV_W-1:0] ipl_dev = '0;
  logic             ipoll = 0, dpc = 0, poll_done = 0, svc_done = 0;
  logic [N_DEV-1:0] cs = '0;
  logic             poll_gnt, poll_src, poll_busy, svc_gnt, svc_src, svc_busy, req_err;
  logic [DEV_W-1:0] poll_dev;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_chan_seq #(.N_DEV(N_DEV)) u_io_chan_seq (
    .clk_i(clk), .rst_ni(rst_ni), .ipl_mode_i(ipl_mode), .ipl_dev_i(ipl_dev),
    .ipoll_req_i(ipoll), .cs_req_i(cs), .dpc_req_i(dpc),
    .poll_done_i(poll_done), .svc_done_i(svc_done),
    .poll_gnt_o(poll_gnt), .poll_src_o(poll_src), .poll_dev_o(poll_dev),
    .poll_busy_o(poll_busy), .svc_gnt_o(svc_gnt), .svc_src_o(svc_src),
    .svc_busy_o(svc_busy), .req_err_o(req_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drop all requests, hold both done inputs until everything drains
  task automatic drain();
    cs = '0; ipoll = 0; dpc = 0; ipl_mode = 0;
    poll_done = 1; svc_done = 1;
    cyc(30);
    poll_done = 0; svc_done = 0;
    cyc(1);
    chk(!poll_busy && !svc_busy, "R4 drain idle", int'(poll_busy | svc_busy), 0);
  endtask

  // wait for a poll grant, check winner, drop its request
  task automatic take_poll(input bit src, input int dev, input string req);
    int n = 0;
    while (!poll_gnt && n < 40) begin @(negedge clk); n++; end
    chk(poll_gnt && poll_src == src && (src || int'(poll_dev) == dev), req,
        poll_gnt ? (poll_src ? 100 : int'(poll_dev)) : -1, src ? 100 : dev);
    if (src) ipoll = 0; else cs[dev] = 0;
  endtask

  // service the hand-off and end both transactions
  task automatic finish_pair(input string req);
    int n = 0;
    while (!svc_gnt && n < 40) begin @(negedge clk); n++; end
    chk(svc_gnt && svc_src == 1'b0, req, int'(svc_src), 0);
    poll_done = 1; svc_done = 1;
    cyc(1);
    poll_done = 0; svc_done = 0;
  endtask

  task automatic t_reset();
    rst_ni = 0;
    cyc(3);
    chk(!poll_busy && !svc_busy && !poll_gnt && !svc_gnt, "R1 in reset",
        int'({poll_busy, svc_busy, poll_gnt, svc_gnt}), 0);
    rst_ni = 1;
    cyc(3);
    chk(!poll_busy && !svc_busy && !poll_gnt && !svc_gnt, "R1 after release",
        int'({poll_busy, svc_busy, poll_gnt, svc_gnt}), 0);
  endtask

  task automatic t_basic();
    cs[2] = 1;
    cyc(1);
    chk(poll_gnt && !poll_src && poll_dev == 3'd2 && poll_busy, "R2 grant",
        int'(poll_dev), 2);
    chk(!svc_gnt, "R5 not same cycle", int'(svc_gnt), 0);
    cs[2] = 0;
    cyc(1);
    chk(!poll_gnt && poll_busy, "R2 one-cycle pulse", int'(poll_gnt), 0);
    chk(svc_gnt && svc_src == 1'b0 && svc_busy, "R5 hand-off next cycle",
        int'(svc_gnt), 1);
    poll_done = 1;
    cyc(1);
    poll_done = 0;
    chk(!poll_busy && svc_busy, "R4 poll done", int'(poll_busy), 0);
    svc_done = 1;
    cyc(1);
    svc_done = 0;
    chk(!svc_busy, "R4 svc done", int'(svc_busy), 0);
    cyc(3);
    chk(!poll_gnt && !svc_gnt && !poll_busy, "R2 no spurious grant",
        int'(poll_busy), 0);
  endtask

  task automatic t_poll_prio();
    ipoll = 1; cs[3] = 1; cs[1] = 1;
    cyc(1);
    take_poll(1'b0, 1, "R3 lowest device first");
    finish_pair("R5 hand-off dev1");
    take_poll(1'b0, 3, "R3 cycle steal before poll");
    finish_pair("R5 hand-off dev3");
    take_poll(1'b1, 0, "R3 interrupt poll kept pending");
    finish_pair("R5 hand-off ipoll");
    drain();
  endtask

  task automatic t_busy_hold();
    int seen = 0;
    cs[0] = 1;
    cyc(1);
    take_poll(1'b0, 0, "R2 dev0");
    cyc(1);
    chk(svc_gnt && !svc_src, "R5 dev0 hand-off", int'(svc_gnt), 1);
    svc_done = 1; cyc(1); svc_done = 0;
    ipoll = 1; cyc(1); ipoll = 0;
    for (int i = 0; i < 5; i++) begin cyc(1); if (poll_gnt) seen++; end
    chk(seen == 0 && poll_busy, "R4 no grant while busy", seen, 0);
    poll_done = 1;
    cyc(1);
    poll_done = 0;
    chk(!poll_busy && !poll_gnt, "R4 free after done", int'(poll_busy), 0);
    cyc(1);
    chk(poll_gnt && poll_src, "R4 pulsed request served next", int'(poll_gnt), 1);
    finish_pair("R5 ipoll hand-off");
    drain();
  endtask

  task automatic t_handoff_vs_dpc();
    dpc = 1;
    cyc(1);
    chk(svc_gnt && svc_src, "R6 dpc grant src", int'(svc_src), 1);
    dpc = 0; cs[4] = 1;
    cyc(1);
    chk(poll_gnt && poll_dev == 3'd4 && svc_busy && poll_busy, "R7 both busy",
        int'({poll_busy, svc_busy}), 3);
    cs[4] = 0; poll_done = 1; cs[5] = 1;
    cyc(1);
    poll_done = 0;
    chk(!poll_busy, "R7 poll done", int'(poll_busy), 0);
    cyc(1);
    chk(!poll_gnt && !svc_gnt, "R7 poll waits for hand-off", int'(poll_gnt), 0);
    svc_done = 1; dpc = 1;
    cyc(1);
    svc_done = 0; dpc = 0;
    chk(!svc_gnt && !svc_busy, "R4 svc free", int'(svc_busy), 0);
    cyc(1);
    chk(svc_gnt && svc_src == 1'b0, "R6 hand-off beats dpc", int'(svc_src), 0);
    take_poll(1'b0, 5, "R7 poll resumes after hand-off");
    drain();
  endtask

  task automatic t_err();
    ipoll = 1; dpc = 1;
    #1;
    chk(req_err == 1'b1, "R9 flag both", int'(req_err), 1);
    dpc = 0;
    #1;
    chk(req_err == 1'b0, "R9 flag one", int'(req_err), 0);
    cyc(1);
    drain();
  endtask

  task automatic t_ipl();
    int seen = 0;
    ipl_mode = 1; ipl_dev = 3'd6;
    cs[2] = 1; cs[6] = 1; ipoll = 1;
    cyc(1);
    chk(poll_gnt && !poll_src && poll_dev == 3'd6, "R10 selected device only",
        int'(poll_dev), 6);
    cs[6] = 0; ipoll = 0;
    finish_pair("R10 hand-off in IPL");
    dpc = 1; cyc(1); dpc = 0;
    for (int i = 0; i < 6; i++) begin cyc(1); if (poll_gnt || svc_gnt) seen++; end
    chk(seen == 0, "R10 others masked", seen, 0);
    ipl_mode = 0;
    cyc(1);
    chk(poll_gnt && !poll_src && poll_dev == 3'd2, "R10 masked cs served after",
        int'(poll_dev), 2);
    chk(svc_gnt && svc_src, "R10 masked dpc served after", int'(svc_gnt), 1);
    cs[2] = 0;
    drain();
  endtask

  task automatic t_async_reset();
    int seen = 0;
    cs[0] = 1;
    cyc(1);
    cs[0] = 0;
    cyc(1);
    ipoll = 1; cyc(1); ipoll = 0;
    chk(poll_busy && svc_busy, "R11 both busy before", int'({poll_busy, svc_busy}), 3);
    #2 rst_ni = 0;
    #1;
    chk(!poll_busy && !svc_busy, "R11 cleared without edge",
        int'({poll_busy, svc_busy}), 0);
    @(negedge clk);
    rst_ni = 1;
    for (int i = 0; i < 5; i++) begin cyc(1); if (poll_gnt || svc_gnt) seen++; end
    chk(seen == 0, "R11 pending cleared", seen, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_poll_prio();
    t_busy_hold();
    t_handoff_vs_dpc();
    t_err();
    t_ipl();
    t_async_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule